// File: doc/BRIEF.md
# Word-Serial Signature Compressor

This block folds a stream of test-response words into one signature register. It follows the way a processor builds a signature in software during a self-test run. A word is taken on every clock cycle in which its valid strobe is high. The signature first moves right by one bit, and the bit that leaves position 0 is kept as a carry. When that carry is 1, the feedback polynomial is XORed into the shifted value. The incoming word is XORed in last. The feedback polynomial is an input rather than a fixed tap set, so it can change from one word to the next.

A clear starts a new run. It loads a seed into the signature, zeroes the word counter and latches how many words the run should absorb. When that many words have been taken, a done flag rises. Any further valid words are then dropped until the next clear. The signature can be compared against an expected value elsewhere once done is high.

Top module: `resp_sig_compactor`

## Requirements
- R1: After synchronous reset the signature is zero, the word count is zero and done is 1. While done is 1 no word is absorbed, so a clear is needed before the first run.
- R2: A clear loads the signature with `seed_i`, sets the word count to 0 and latches `word_target_i`. The new values are visible after the next rising edge. A clear takes priority over a valid word in the same cycle, and that word is not absorbed.
- R3: An absorbed word updates the signature in one cycle to ((S >> 1) XOR (S[0] ? P : 0)) XOR D. Here S is the old signature, P is `poly_i` and D is `din_i`. Bit 0 is the least significant bit.
- R4: The polynomial used for each word is the value on `poly_i` in that word's cycle. Changing it between words changes only the updates that follow.
- R5: In a cycle with neither clear nor valid, the signature, the count and done keep their values.
- R6: Each absorbed word increments `word_cnt_o` by one, and the new count is visible after the same edge that updates the signature.
- R7: Done rises after the edge on which the count reaches the latched target. A target of 0 makes done high straight after the clear.
- R8: While done is high, valid words change neither the signature nor the count, until a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clr_i | input | 1 | Start a new run: load the seed, zero the count, latch the target |
| seed_i | input | WIDTH | Starting signature, loaded by a clear |
| word_target_i | input | CNT_W | Number of words in the run, latched by a clear |
| poly_i | input | WIDTH | Feedback polynomial for the current word |
| din_i | input | WIDTH | Response word |
| din_vld_i | input | 1 | Response word valid |
| sig_o | output | WIDTH | Current signature |
| word_cnt_o | output | CNT_W | Words absorbed since the last clear |
| done_o | output | 1 | Target word count reached |

## Verification
Every result is registered once. A clear or an absorbed word therefore shows on `sig_o`, `word_cnt_o` and `done_o` after the first rising edge that follows it, with no pipeline beyond that. The bench drives each cycle's inputs on the falling edge and advances its reference model by one step for those inputs. It then compares all three outputs on the next falling edge, half a period after the edge that registers them. Runs with a fixed polynomial, runs with a new polynomial on every word, gaps in the valid strobe, words offered after done, and a clear in the same cycle as a valid word are each compared against the model in that cycle.

// File: rtl/sigc_pkg.sv
package sigc_pkg;

    // What the register stage does in a given cycle
    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_CLEAR   = 2'd1,
        OP_ABSORB  = 2'd2,
        OP_BLOCKED = 2'd3
    } sigc_op_e;

endpackage

// File: rtl/sigc_ctrl.sv
module sigc_ctrl
    import sigc_pkg::*;
(
    input  logic     clr_i,
    input  logic     vld_i,
    input  logic     done_i,
    output sigc_op_e op_o
);

    // Clear wins over data; data after done is dropped
    always_comb begin
        if (clr_i)
            op_o = OP_CLEAR;
        else if (vld_i && done_i)
            op_o = OP_BLOCKED;
        else if (vld_i)
            op_o = OP_ABSORB;
        else
            op_o = OP_IDLE;
    end

endmodule

// File: rtl/sigc_step.sv
module sigc_step #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] sig_i,
    input  logic [WIDTH-1:0] poly_i,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] sig_o
);

    logic carry;
    assign carry = sig_i[0];

    // One bit slice per signature position: shifted-in bit, feedback tap, data
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        if (b == WIDTH - 1) begin : g_top
            assign sig_o[b] = (carry & poly_i[b]) ^ din_i[b];
        end else begin : g_mid
            assign sig_o[b] = sig_i[b+1] ^ (carry & poly_i[b]) ^ din_i[b];
        end
    end

endmodule

// File: rtl/sigc_counter.sv
module sigc_counter
    import sigc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  sigc_op_e         op_i,
    input  logic [CNT_W-1:0] target_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             done_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] tgt;
        logic             done;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CNT_W-1:0] cnt_inc;

    assign cnt_inc = st_q.cnt + CNT_W'(1);

    always_comb begin
        st_d = st_q;
        case (op_i)
            OP_CLEAR: begin
                st_d.cnt  = '0;
                st_d.tgt  = target_i;
                st_d.done = (target_i == '0);
            end
            OP_ABSORB: begin
                st_d.cnt  = cnt_inc;
                st_d.done = (cnt_inc == st_q.tgt);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt  <= '0;
            st_q.tgt  <= '0;
            st_q.done <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign done_o = st_q.done;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_ABSORB) |=> (cnt_o == $past(cnt_o) + CNT_W'(1))); // R6
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (done_o && op_i != OP_CLEAR) |=> done_o); // R8
    AST_CNT_BELOW_TGT: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> (cnt_o < st_q.tgt)); // R7

endmodule

// File: rtl/resp_sig_compactor.sv
module resp_sig_compactor
    import sigc_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic [WIDTH-1:0] seed_i,
    input  logic [CNT_W-1:0] word_target_i,
    input  logic [WIDTH-1:0] poly_i,
    input  logic [WIDTH-1:0] din_i,
    input  logic             din_vld_i,
    output logic [WIDTH-1:0] sig_o,
    output logic [CNT_W-1:0] word_cnt_o,
    output logic             done_o
);

    typedef struct packed {
        logic [WIDTH-1:0] sig;
    } sig_state_t;

    sig_state_t       st_d, st_q;
    sigc_op_e         op;
    logic [WIDTH-1:0] sig_next;

    sigc_ctrl u_ctrl (
        .clr_i  (clr_i),
        .vld_i  (din_vld_i),
        .done_i (done_o),
        .op_o   (op)
    );

    sigc_step #(.WIDTH(WIDTH)) u_step (
        .sig_i  (st_q.sig),
        .poly_i (poly_i),
        .din_i  (din_i),
        .sig_o  (sig_next)
    );

    sigc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .op_i     (op),
        .target_i (word_target_i),
        .cnt_o    (word_cnt_o),
        .done_o   (done_o)
    );

    always_comb begin
        st_d = st_q;
        case (op)
            OP_CLEAR:  st_d.sig = seed_i;
            OP_ABSORB: st_d.sig = sig_next;
            default:   ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q.sig <= '0;
        else     st_q <= st_d;
    end

    assign sig_o = st_q.sig;

    AST_SIG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !din_vld_i) |=> $stable(sig_o)); // R5
    AST_CLR_SEED: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (sig_o == $past(seed_i) && word_cnt_o == '0)); // R2
    AST_BLOCKED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && din_vld_i && done_o) |=> ($stable(sig_o) && $stable(word_cnt_o))); // R8

endmodule

// File: tb/resp_sig_compactor_bench.sv
`timescale 1ns/100ps
module resp_sig_compactor_bench;

    localparam int W  = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          clr;
    logic [W-1:0]  seed, poly, din;
    logic [CW-1:0] tgt;
    logic          vld;
    logic [W-1:0]  sig;
    logic [CW-1:0] cnt;
    logic          done;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [W-1:0]  m_sig;
    logic [CW-1:0] m_cnt;
    logic [CW-1:0] m_tgt;
    logic          m_done;

    always #2.5 clk = ~clk;

    resp_sig_compactor #(.WIDTH(W), .CNT_W(CW)) u_resp_sig_compactor (
        .clk(clk), .rst(rst), .clr_i(clr), .seed_i(seed), .word_target_i(tgt),
        .poly_i(poly), .din_i(din), .din_vld_i(vld),
        .sig_o(sig), .word_cnt_o(cnt), .done_o(done)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check(tag, sig, m_sig);
        check("R6", W'(cnt), W'(m_cnt));
        check("R7", W'(done), W'(m_done));
    endtask

    // Called on a falling edge: drive, step model, wait for edge, compare.
    task automatic cyc(input logic c, input logic v, input logic [W-1:0] d,
                       input logic [W-1:0] p, input logic [W-1:0] s,
                       input logic [CW-1:0] t, input string tag);
        logic carry;
        clr = c; vld = v; din = d; poly = p; seed = s; tgt = t;
        if (c) begin
            m_sig = s; m_cnt = '0; m_tgt = t; m_done = (t == '0);
        end else if (v && !m_done) begin
            carry = m_sig[0];
            m_sig = (m_sig >> 1) ^ (carry ? p : '0) ^ d;
            m_cnt = m_cnt + 1'b1;
            m_done = (m_cnt == m_tgt);
        end
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] fixp;
        rst = 1'b1; clr = 0; vld = 0; din = '0; poly = '0; seed = '0; tgt = '0;
        m_sig = '0; m_cnt = '0; m_tgt = '0; m_done = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare_all("R1");
        rst = 1'b0;
        // R8/R1: word after reset is dropped because done starts high
        cyc(0, 1, 32'hDEADBEEF, 32'h04C11DB7, '0, '0, "R8");

        // R3 with fixed polynomial, R5 idle gaps
        fixp = 32'hEDB88320;
        cyc(1, 0, '0, fixp, '0, 16'd8, "R2");
        for (int i = 0; i < 8; i++) begin
            cyc(0, 1, $urandom, fixp, '0, '0, "R3");
            if (i % 3 == 1) cyc(0, 0, $urandom, $urandom, $urandom, $urandom, "R5");
        end
        // R8: extra words after done
        for (int i = 0; i < 4; i++) cyc(0, 1, $urandom, $urandom, '0, '0, "R8");

        // R2: clear together with valid; word is not absorbed
        cyc(1, 1, 32'hFFFF0000, 32'h1, 32'h80000001, 16'd20, "R2");
        // R4: new polynomial every word
        for (int i = 0; i < 20; i++) cyc(0, 1, $urandom, $urandom, '0, '0, "R4");
        cyc(0, 1, 32'h12345678, 32'h0F0F0F0F, '0, '0, "R8");

        // R7: target 0 and target 1
        cyc(1, 0, '0, '0, 32'hA5A5A5A5, 16'd0, "R7");
        cyc(0, 1, 32'h1, 32'h3, '0, '0, "R8");
        cyc(1, 0, '0, '0, 32'h00000001, 16'd1, "R7");
        cyc(0, 1, 32'h0, 32'hC0000000, '0, '0, "R3");
        cyc(0, 1, 32'h0, 32'hC0000000, '0, '0, "R8");

        // mixed random traffic
        for (int i = 0; i < 400; i++) begin
            logic c, v;
            c = ($urandom % 40) == 0;
            v = ($urandom % 4) != 0;
            cyc(c, v, $urandom, $urandom, $urandom, CW'(1 + $urandom % 50),
                c ? "R2" : (v ? "R3" : "R5"));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule